// File: doc/BRIEF.md
# Address-Event Pixel Receiver with Leaky Integration

This block takes a spike stream from an imager and turns it into a grey-level pixel map. The imager sends spikes as an address-event stream over a request/acknowledge handshake. The receiver brings the request lines into its own clock domain and acknowledges each address with a four-phase handshake. It works out from the position of each address within a burst whether that address names a chip, a row or a column, and it counts spikes per pixel in small saturating counters.

A free-running step timer fires once every `STEP_CYCLES` clock cycles. Each time it fires, a sweep visits every pixel in turn, one pixel per cycle. For each pixel the sweep takes the stored value, multiplies it by a fixed leak factor of about 0.914, and adds the spike count scaled by 1/32. It stores the result and writes it out on a simple write port that feeds the image memory of a downstream filter core. It then clears the pixel's counter. The stored value therefore follows the spike rate as a leaky integral: it decays towards zero when the pixel is quiet and rises while the pixel keeps firing.

Top module: `aer_leaky_rx`

## Requirements
- R1: After reset, `ack_n` is 1 and `img_we` is 0. Every pixel value and every spike counter starts at zero, so a sweep with no spikes writes 0 to every address.
- R2: Both request inputs pass through a two-flop synchroniser. Once the synchronised `col_req_n` is seen low, `ack_n` goes low. It stays low as long as the synchronised strobe stays low. It returns high after the strobe has returned high.
- R3: `row_req` going high opens a burst. The first acknowledged address of a burst is the chip address. The second is the row address, taken from its low ROW_W bits. Each later address is a column, taken from its low COL_W bits, and counts one spike at pixel index row*2^COL_W + col. When `row_req` goes low, the next burst starts again with a chip address.
- R4: A burst whose chip address (low CHIP_W bits) differs from `LOCAL_ID` is still acknowledged, but its columns count no spikes. Strobes that arrive while `row_req` is low are also acknowledged and ignored.
- R5: Sweeps repeat every `STEP_CYCLES` cycles. Each sweep writes all 2^(ROW_W+COL_W) pixels on consecutive cycles, in ascending address order from 0.
- R6: Each pixel value is unsigned, with 12 fraction bits. The written value is floor(old*59891/65536) + n*128, where n is the pixel's spike count for the step.
- R7: A pixel's spike counter saturates at 2^CNT_W-1 (15) and does not wrap.
- R8: The sweep clears a pixel's counter after it updates that pixel. If a spike for that pixel arrives in the same cycle as its update, the spike is counted towards the next step and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_req | input | 1 | High while a burst is in progress (asynchronous) |
| col_req_n | input | 1 | Active-low strobe, one for each address presented (asynchronous) |
| aer_addr | input | ADDR_W | Address value; held stable while `col_req_n` is low |
| ack_n | output | 1 | Active-low acknowledge |
| img_we | output | 1 | Image memory write enable |
| img_addr | output | ROW_W+COL_W | Pixel address of the write |
| img_data | output | 16 | Updated pixel value |

## Verification
Spike counting and the step sweep run independently, so a spike can land on a pixel in the very cycle that the sweep updates and clears that pixel's counter. The bench provokes this by sending short bursts to the last pixel, starting each burst at an offset from the step boundary that grows by one cycle on every pass. Over the passes, spike arrival walks across the clear cycle. The bench recovers each step's count from the written value (it removes the leaked previous value and divides by 128). It then requires the recovered counts, summed over all steps, to equal the number of spikes sent, so no spike can be lost or counted twice at the collision.

// File: rtl/aer_rx_pkg.sv
package aer_rx_pkg;

  localparam int VAL_W     = 16;     // unsigned, 12 fraction bits
  localparam int CNT_W     = 4;      // per-pixel spike counter
  localparam int LEAK_Q16  = 59891;  // exp(-10ms/111ms) in Q0.16
  localparam int CNT_SHIFT = 7;      // n * 1/32 in 12-fraction-bit units

  typedef logic [VAL_W-1:0] val_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {PH_CHIP, PH_ROW, PH_COL} phase_e;

  // One leaky integration step for a single pixel.
  function automatic val_t leak_step(val_t old_v, cnt_t n);
    logic [31:0]    prod;
    logic [VAL_W:0] sum;
    prod = 32'(old_v) * 32'(LEAK_Q16);
    sum  = (VAL_W+1)'(prod[VAL_W+15:16]) + ((VAL_W+1)'(n) << CNT_SHIFT);
    return sum[VAL_W] ? {VAL_W{1'b1}} : sum[VAL_W-1:0];
  endfunction

  // Saturating increment of a spike counter.
  function automatic cnt_t sat_inc(cnt_t c);
    return (&c) ? c : c + 1'b1;
  endfunction

endpackage

// File: rtl/aer_hs_sync.sv
module aer_hs_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_req,
  input  logic col_req_n,
  output logic burst_s,
  output logic strb_s,
  output logic acc,
  output logic ack_n
);

  logic [SYNC_N-1:0] row_sh, strb_sh;
  logic              ack_q;

  // Synchroniser chains; the strobe is inverted so that 1 means "address presented".
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_sh  <= '0;
      strb_sh <= '0;
    end else begin
      row_sh  <= {row_sh[SYNC_N-2:0], row_req};
      strb_sh <= {strb_sh[SYNC_N-2:0], ~col_req_n};
    end
  end

  assign burst_s = row_sh[SYNC_N-1];
  assign strb_s  = strb_sh[SYNC_N-1];

  // Four-phase handshake: accept once, hold acknowledge until the strobe releases.
  assign acc = strb_s && !ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ack_q <= 1'b0;
    else if (acc)     ack_q <= 1'b1;
    else if (!strb_s) ack_q <= 1'b0;
  end

  assign ack_n = ~ack_q;

endmodule

// File: rtl/aer_addr_seq.sv
module aer_addr_seq import aer_rx_pkg::*; #(
  parameter int ADDR_W   = 4,
  parameter int CHIP_W   = 4,
  parameter int ROW_W    = 3,
  parameter int COL_W    = 3,
  parameter int LOCAL_ID = 5,
  localparam int PIX_W   = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_s,
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  output logic              spk_vld,
  output logic [PIX_W-1:0]  spk_idx
);

  phase_e            phase_q;
  logic              chip_ok_q;
  logic [ROW_W-1:0]  row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CHIP;
      chip_ok_q <= 1'b0;
      row_q     <= '0;
      spk_vld   <= 1'b0;
      spk_idx   <= '0;
    end else begin
      spk_vld <= 1'b0;
      if (!burst_s) begin
        phase_q <= PH_CHIP;                // stray strobes outside a burst are dropped
      end else if (acc) begin
        unique case (phase_q)
          PH_CHIP: begin
            chip_ok_q <= (addr[CHIP_W-1:0] == CHIP_W'(LOCAL_ID));
            phase_q   <= PH_ROW;
          end
          PH_ROW: begin
            row_q   <= addr[ROW_W-1:0];
            phase_q <= PH_COL;
          end
          default: begin
            spk_vld <= chip_ok_q;
            spk_idx <= {row_q, addr[COL_W-1:0]};
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/aer_leak_array.sv
module aer_leak_array import aer_rx_pkg::*; #(
  parameter int PIX_W       = 6,
  parameter int STEP_CYCLES = 2_000_000,
  localparam int NPIX       = 1 << PIX_W,
  localparam int TICK_W     = $clog2(STEP_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spk_vld,
  input  logic [PIX_W-1:0] spk_idx,
  output logic             img_we,
  output logic [PIX_W-1:0] img_addr,
  output val_t             img_data
);

  logic [TICK_W-1:0]           tick_q;
  logic                        tick;
  logic                        sweeping;
  logic [PIX_W-1:0]            idx_q;
  logic [NPIX-1:0][CNT_W-1:0]  cnt_q, cnt_nxt;
  val_t                        val_mem [NPIX];
  val_t                        upd;

  // Step timer
  assign tick = (tick_q == TICK_W'(STEP_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick ? '0 : tick_q + 1'b1;
  end

  // Sweep sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweeping <= 1'b0;
      idx_q    <= '0;
    end else if (!sweeping) begin
      if (tick) begin
        sweeping <= 1'b1;
        idx_q    <= '0;
      end
    end else begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == PIX_W'(NPIX - 1)) sweeping <= 1'b0;
    end
  end

  // Per-pixel counters: a spike arriving on the clear cycle seeds the next step.
  for (genvar g = 0; g < NPIX; g++) begin : g_cnt
    logic hit, clr;
    assign hit = spk_vld && (spk_idx == PIX_W'(g));
    assign clr = sweeping && (idx_q == PIX_W'(g));
    assign cnt_nxt[g] = clr ? (hit ? CNT_W'(1) : '0)
                            : (hit ? sat_inc(cnt_q[g]) : cnt_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // Value memory and the output write port
  assign upd = leak_step(val_mem[idx_q], cnt_q[idx_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) val_mem[i] <= '0;
      img_we   <= 1'b0;
      img_addr <= '0;
      img_data <= '0;
    end else begin
      if (sweeping) val_mem[idx_q] <= upd;
      img_we   <= sweeping;
      img_addr <= idx_q;
      img_data <= upd;
    end
  end

endmodule

// File: rtl/aer_leaky_rx.sv
module aer_leaky_rx import aer_rx_pkg::*; #(
  parameter int ROW_W       = 3,
  parameter int COL_W       = 3,
  parameter int CHIP_W      = 4,
  parameter int ADDR_W      = 4,
  parameter int LOCAL_ID    = 5,
  parameter int SYNC_N      = 2,
  parameter int STEP_CYCLES = 2_000_000,
  localparam int PIX_W      = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_req,
  input  logic              col_req_n,
  input  logic [ADDR_W-1:0] aer_addr,
  output logic              ack_n,
  output logic              img_we,
  output logic [PIX_W-1:0]  img_addr,
  output logic [VAL_W-1:0]  img_data
);

  // Named internal events, also observed by the checker
  logic             burst_s;
  logic             strb_s;
  logic             acc;
  logic             spk_vld;
  logic [PIX_W-1:0] spk_idx;

  aer_hs_sync #(.SYNC_N(SYNC_N)) u_hs (
    .clk(clk), .rst_n(rst_n), .row_req(row_req), .col_req_n(col_req_n),
    .burst_s(burst_s), .strb_s(strb_s), .acc(acc), .ack_n(ack_n)
  );

  aer_addr_seq #(
    .ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .ROW_W(ROW_W), .COL_W(COL_W), .LOCAL_ID(LOCAL_ID)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .burst_s(burst_s), .acc(acc), .addr(aer_addr),
    .spk_vld(spk_vld), .spk_idx(spk_idx)
  );

  aer_leak_array #(.PIX_W(PIX_W), .STEP_CYCLES(STEP_CYCLES)) u_arr (
    .clk(clk), .rst_n(rst_n), .spk_vld(spk_vld), .spk_idx(spk_idx),
    .img_we(img_we), .img_addr(img_addr), .img_data(img_data)
  );

endmodule

// File: rtl/aer_rx_checker.sv
module aer_rx_checker #(
  parameter int PIX_W = 6,
  localparam logic [PIX_W-1:0] LAST = {PIX_W{1'b1}}
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_n,
  input logic             strb_s,
  input logic             acc,
  input logic             spk_vld,
  input logic             img_we,
  input logic [PIX_W-1:0] img_addr
);

  p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && strb_s) |=> !ack_n);

  p_ack_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !strb_s) |=> ack_n);

  p_ack_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(strb_s));

  p_spike_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spk_vld |-> $past(acc));

  p_sweep_from_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(img_we) |-> (img_addr == '0));

  p_sweep_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (img_we && img_addr != LAST) |=> (img_we && img_addr == $past(img_addr) + 1'b1));

endmodule

bind aer_leaky_rx aer_rx_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .strb_s(strb_s), .acc(acc),
  .spk_vld(spk_vld), .img_we(img_we), .img_addr(img_addr)
);

// File: tb/test_aer_leaky_rx.sv
module test_aer_leaky_rx;

  localparam int ROW_W = 3, COL_W = 3, CHIP_W = 4, ADDR_W = 4;
  localparam int LOCAL_ID = 5, STEP = 2000;
  localparam int PIX_W = ROW_W + COL_W, NPIX = 1 << PIX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_req = 1'b0, col_req_n = 1'b1;
  logic [ADDR_W-1:0] aer_addr = '0;
  logic ack_n, img_we;
  logic [PIX_W-1:0] img_addr;
  logic [15:0] img_data;

  always #2.5 clk = ~clk;   // 200 MHz

  aer_leaky_rx #(.ROW_W(ROW_W), .COL_W(COL_W), .CHIP_W(CHIP_W), .ADDR_W(ADDR_W),
                 .LOCAL_ID(LOCAL_ID), .STEP_CYCLES(STEP)) i_aer_leaky_rx (
    .clk(clk), .rst_n(rst_n), .row_req(row_req), .col_req_n(col_req_n),
    .aer_addr(aer_addr), .ack_n(ack_n), .img_we(img_we), .img_addr(img_addr),
    .img_data(img_data));

  int checks = 0, failures = 0;
  int prev_v [NPIX], last_n [NPIX], tot_obs [NPIX];
  int sweeps = 0, exp_idx = 0, cyc = 0, last_end = -1;
  int sent63 = 0;
  bit cur_local = 0;
  int cur_row = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Independent restatement of the leak: integer division of the scaled product.
  function automatic int leak_of(int v);
    longint p = longint'(v) * 59891;
    return int'(p / 65536);
  endfunction

  // Write-port monitor
  always @(negedge clk) begin
    int lk, d;
    cyc++;
    if (rst_n && img_we) begin
      chk(int'(img_addr) == exp_idx, "R5 sweep order", int'(img_addr), exp_idx);
      lk = leak_of(prev_v[img_addr]);
      d  = int'(img_data) - lk;
      chk(d >= 0 && (d % 128) == 0 && d / 128 <= 15, "R6 value form", int'(img_data), lk);
      last_n[img_addr]  = d / 128;
      tot_obs[img_addr] += d / 128;
      prev_v[img_addr]  = int'(img_data);
      if (exp_idx == NPIX - 1) begin
        if (last_end >= 0) chk(cyc - last_end == STEP, "R5 step period", cyc - last_end, STEP);
        last_end = cyc;
        exp_idx  = 0;
        sweeps++;
      end else exp_idx++;
    end
  end

  task automatic wait_sweep();
    int s = sweeps;
    while (sweeps == s) @(negedge clk);
  endtask

  task automatic send_addr(int a);
    int t = 0;
    @(negedge clk);
    aer_addr  = ADDR_W'(a);
    col_req_n = 1'b0;
    while (ack_n && t < 20) begin @(negedge clk); t++; end
    if (t >= 20) chk(0, "R2 ack timeout", int'(ack_n), 0);
    @(negedge clk);
    col_req_n = 1'b1;
    t = 0;
    while (!ack_n && t < 20) begin @(negedge clk); t++; end
    if (t >= 20) chk(0, "R2 release timeout", int'(ack_n), 1);
  endtask

  task automatic burst_begin(int chip, int row);
    @(negedge clk) row_req = 1'b1;
    repeat (3) @(negedge clk);
    send_addr(chip);
    send_addr(row);
    cur_local = (chip == LOCAL_ID);
    cur_row   = row;
  endtask

  task automatic send_col(int col);
    send_addr(col);
    if (cur_local && cur_row * 8 + col == 63) sent63++;
  endtask

  task automatic burst_end();
    @(negedge clk) row_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // R1: idle state and all-zero first sweep
  task automatic t_reset();
    bit allz = 1;
    chk(ack_n == 1'b1, "R1 ack_n reset", int'(ack_n), 1);
    chk(img_we == 1'b0, "R1 img_we reset", int'(img_we), 0);
    wait_sweep();
    for (int i = 0; i < NPIX; i++) if (prev_v[i] != 0) allz = 0;
    chk(allz, "R1 zero map after reset", int'(allz), 1);
  endtask

  // R2: four-phase handshake at the ports
  task automatic t_handshake();
    int t = 0;
    bit held = 1;
    @(negedge clk) col_req_n = 1'b0;
    while (ack_n && t < 10) begin @(negedge clk); t++; end
    chk(ack_n == 1'b0, "R2 ack asserted", int'(ack_n), 0);
    chk(t >= 2, "R2 sync latency", t, 2);
    repeat (10) begin @(negedge clk); if (ack_n) held = 0; end
    chk(held, "R2 ack held while strobe low", int'(held), 1);
    col_req_n = 1'b1;
    t = 0;
    while (!ack_n && t < 10) begin @(negedge clk); t++; end
    chk(ack_n == 1'b1, "R2 ack released", int'(ack_n), 1);
  endtask

  // R3 / R6: address sequence and first-step value
  task automatic t_basic();
    wait_sweep();
    burst_begin(LOCAL_ID, 2);
    send_col(1); send_col(1); send_col(4);
    burst_end();
    burst_begin(LOCAL_ID, 6);
    send_col(0);
    burst_end();
    wait_sweep();
    chk(last_n[17] == 2, "R3 row2 col1 count", last_n[17], 2);
    chk(last_n[20] == 1, "R3 row2 col4 count", last_n[20], 1);
    chk(last_n[48] == 1, "R3 row6 col0 count", last_n[48], 1);
    chk(last_n[18] == 0, "R3 untouched pixel", last_n[18], 0);
    chk(prev_v[17] == 256, "R6 two spikes from zero", prev_v[17], 256);
  endtask

  // R6: pure decay over a quiet step
  task automatic t_decay();
    wait_sweep();
    chk(prev_v[17] == 233, "R6 decayed value", prev_v[17], 233);
    chk(prev_v[20] == 116, "R6 decayed single", prev_v[20], 116);
  endtask

  // R4: foreign chip and stray strobes
  task automatic t_foreign();
    wait_sweep();
    burst_begin(3, 1);
    send_col(2); send_col(3);
    burst_end();
    send_addr(LOCAL_ID); send_addr(1); send_addr(2);   // no burst open
    burst_begin(LOCAL_ID, 1);
    send_col(5);
    burst_end();
    wait_sweep();
    chk(last_n[10] == 0, "R4 foreign col2 ignored", last_n[10], 0);
    chk(last_n[11] == 0, "R4 foreign col3 ignored", last_n[11], 0);
    chk(last_n[13] == 1, "R4 local burst after foreign", last_n[13], 1);
  endtask

  // R7 / R8: saturation then clear
  task automatic t_saturate();
    wait_sweep();
    burst_begin(LOCAL_ID, 3);
    repeat (20) send_col(3);
    burst_end();
    wait_sweep();
    chk(last_n[27] == 15, "R7 counter saturates", last_n[27], 15);
    burst_begin(LOCAL_ID, 3);
    send_col(3);
    burst_end();
    wait_sweep();
    chk(last_n[27] == 1, "R8 counter cleared after update", last_n[27], 1);
  endtask

  // R8: spikes walked across the update cycle of pixel 63
  task automatic t_collide();
    for (int off = 0; off < 16; off++) begin
      wait_sweep();
      repeat (STEP - 40 + off) @(negedge clk);
      burst_begin(LOCAL_ID, 7);
      send_col(7); send_col(7); send_col(7);
      burst_end();
    end
    wait_sweep();
    wait_sweep();
    chk(tot_obs[63] == sent63, "R8 no spike lost at collision", tot_obs[63], sent63);
  endtask

  initial begin
    for (int i = 0; i < NPIX; i++) begin prev_v[i] = 0; last_n[i] = 0; tot_obs[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_handshake();
    t_basic();
    t_decay();
    t_foreign();
    t_saturate();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule